// File: doc/BRIEF.md
# Guard-Timed Contactless Frame Transmitter

This block sends one framed message at a time as a stream of bytes. After a start request it waits for a legal launch instant. It then emits a run of zero preamble bytes, a two-byte sync word, a length byte, the payload taken from a streaming source, a 16-bit CRC that it computes itself, and two zero filler bytes. Every byte is offered on a ready/valid output. From the first preamble byte to the last filler byte the valid signal never drops.

Launch times are measured in ticks, where one tick stands for 16 carrier cycles. An internal counter counts the `tick_i` strobes from reset, with the first value 0. The block keeps an "earliest allowed" time, E. E is pushed forward by each launch, to enforce the request-to-request guard of 426 ticks, and by each `rx_end_i` event, to enforce the 168-tick receive-to-transmit turnaround. A frame launches at ((max(E, now) rounded down to a multiple of 8) + 8).

A start request that arrives while a frame is waiting or in flight is held, and it is served once that frame has finished.

Top module: `nfc_frame_tx`

## Requirements
- R1: While reset is asserted, and after reset is released, `out_valid_o`, `busy_o` and `pl_rd_o` are 0; a reset in the middle of a frame drops them at once.
- R2: A frame is sent in this order: six 0x00 bytes, then 0xB2, then 0x4D, then a length byte equal to the payload count `len_i` plus one, then the payload bytes in source order, then the CRC high byte, then the CRC low byte, then two 0x00 bytes.
- R3: The CRC is CRC-16 with polynomial 0x1021 and initial value 0x0000. It is computed MSB-first over the length byte followed by the payload bytes.
- R4: With `len_i` = 0 the length byte is 0x01, no payload byte is read, and the CRC is taken over the byte 0x01 alone.
- R5: If a start request is sampled at a clock edge where the tick counter holds N, the launch time is S = ((max(E, N) with its low three bits cleared) + 8). The first preamble byte becomes valid in the cycle in which the counter first reads S+1, with `tick_i` high every cycle.
- R6: A launch at S raises E to at least S + 426, so the next launch is no earlier than S + 426.
- R7: An `rx_end_i` pulse sampled while the counter holds M raises E to at least M + 168.
- R8: A start request made while `busy_o` is high is held, with its length. It is served after the current frame, with launch time ((E rounded down to a multiple of 8) + 8).
- R9: Once a frame has begun, `out_valid_o` stays high until the last filler byte is accepted. While `out_ready_i` is low, `out_data_o` holds its value.
- R10: `pl_rd_o` is high exactly in the cycles in which a payload byte is accepted, and `out_data_o` equals `pl_data_i` in those cycles.
- R11: `busy_o` is high from the edge that takes a start request until the last filler byte is accepted, and stays high while a held request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per 16 carrier cycles; advances the tick counter |
| rx_end_i | input | 1 | Pulse marking the end of a received frame |
| start_i | input | 1 | Request to send one frame |
| len_i | input | LEN_W | Payload byte count for the request |
| pl_rd_o | output | 1 | Pops one payload byte from the source |
| pl_data_i | input | 8 | Current head byte of the payload source |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| busy_o | output | 1 | Frame waiting, in flight, or request pending |

## Verification
The bench builds the block with its default parameters: 8-bit lengths, a 24-bit tick counter, a 426-tick guard and a 168-tick turnaround. With `tick_i` held high every cycle, the tick counter and the cycle count agree, so exact launch cycles can be predicted from the guard, turnaround and 8-tick alignment arithmetic. The gaps in the vector table are chosen so that sometimes the current time sets the launch and sometimes the guard or the turnaround does. Half-rate `out_ready_i` exercises backpressure. Zero-length payloads, held requests and a reset in the middle of a frame are covered by directed tests.

// File: rtl/nfc_tx_pkg.sv
package nfc_tx_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_WAIT, ST_PRE, ST_SYNC0, ST_SYNC1,
        ST_LEN, ST_PAY, ST_CRCH, ST_CRCL, ST_TAIL
    } tx_state_e;

    localparam logic [7:0]  SYNC_FIRST  = 8'hB2;
    localparam logic [7:0]  SYNC_SECOND = 8'h4D;
    localparam logic [7:0]  FILL_BYTE   = 8'h00;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
endpackage

// File: rtl/nfc_crc16_step.sv
module nfc_crc16_step
    import nfc_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [15:0]       crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [15:0]       crc_o
);
    logic [15:0] acc;

    // MSB-first shift of one input word into the running remainder
    always_comb begin
        acc = crc_i ^ {data_i, {(16-DATA_W){1'b0}}};
        for (int b = 0; b < DATA_W; b++) begin
            acc = acc[15] ? ((acc << 1) ^ CRC_POLY) : (acc << 1);
        end
        crc_o = acc;
    end
endmodule

// File: rtl/nfc_gap_timer.sv
module nfc_gap_timer #(
    parameter int TICK_W  = 24,
    parameter int GUARD   = 426,
    parameter int FDT     = 168,
    parameter int ALIGN_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx_end_i,
    input  logic arm_i,
    input  logic wait_i,
    input  logic launch_i,
    output logic ready_o
);
    localparam logic [TICK_W-1:0] GUARD_T = TICK_W'(GUARD);
    localparam logic [TICK_W-1:0] FDT_T   = TICK_W'(FDT);
    localparam logic [TICK_W-1:0] STEP_T  = TICK_W'(1 << ALIGN_W);

    typedef struct packed {
        logic [TICK_W-1:0] tcnt;
        logic [TICK_W-1:0] earliest;
        logic [TICK_W-1:0] target;
    } tmr_t;

    tmr_t q, d;

    // a strictly after b, modulo counter wrap
    function automatic logic later(input logic [TICK_W-1:0] a, input logic [TICK_W-1:0] b);
        logic [TICK_W-1:0] diff;
        diff = a - b;
        return (diff != '0) && !diff[TICK_W-1];
    endfunction

    function automatic logic [TICK_W-1:0] latest(input logic [TICK_W-1:0] a, input logic [TICK_W-1:0] b);
        return later(a, b) ? a : b;
    endfunction

    function automatic logic [TICK_W-1:0] align_up(input logic [TICK_W-1:0] x);
        return {x[TICK_W-1:ALIGN_W], {ALIGN_W{1'b0}}} + STEP_T;
    endfunction

    logic [TICK_W-1:0] e_rx;

    always_comb begin
        d      = q;
        d.tcnt = q.tcnt + TICK_W'(tick_i);
        if (arm_i || (wait_i && !later(q.target, q.earliest))) begin
            d.target = align_up(latest(q.earliest, q.tcnt));
        end
        e_rx       = rx_end_i ? latest(q.earliest, q.tcnt + FDT_T) : q.earliest;
        d.earliest = launch_i ? latest(e_rx, q.target + GUARD_T) : e_rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready_o = !later(q.target, q.tcnt) && later(q.target, q.earliest);

    assert_no_early_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !later(q.target, q.tcnt));
    assert_aligned_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (q.target[ALIGN_W-1:0] == '0));
    assert_guard_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> !later($past(q.target) + GUARD_T, q.earliest));
    assert_turnaround_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_end_i |=> !later($past(q.tcnt) + FDT_T, q.earliest));
endmodule

// File: rtl/nfc_frame_tx.sv
module nfc_frame_tx
    import nfc_tx_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int TICK_W      = 24,
    parameter int GUARD_TICKS = 426,
    parameter int FDT_TICKS   = 168,
    parameter int PRE_N       = 6,
    parameter int TAIL_N      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rx_end_i,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             pl_rd_o,
    input  logic [7:0]       pl_data_i,
    output logic             out_valid_o,
    output logic [7:0]       out_data_o,
    input  logic             out_ready_i,
    output logic             busy_o
);
    localparam int CNT_W = LEN_W;

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [15:0]      crc;
        logic             pend;
        logic [LEN_W-1:0] pend_len;
    } seq_t;

    seq_t q, d;
    logic arm, launch, in_wait, tmr_ready, accept;
    logic [15:0] crc_upd;

    nfc_gap_timer #(
        .TICK_W (TICK_W),
        .GUARD  (GUARD_TICKS),
        .FDT    (FDT_TICKS),
        .ALIGN_W(3)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .rx_end_i(rx_end_i),
        .arm_i   (arm),
        .wait_i  (in_wait),
        .launch_i(launch),
        .ready_o (tmr_ready)
    );

    nfc_crc16_step #(.DATA_W(8)) u_crc (
        .crc_i (q.crc),
        .data_i(out_data_o),
        .crc_o (crc_upd)
    );

    always_comb begin
        d       = q;
        arm     = 1'b0;
        launch  = 1'b0;
        in_wait = (q.st == ST_WAIT);
        out_valid_o = !(q.st == ST_IDLE || q.st == ST_WAIT);
        unique case (q.st)
            ST_SYNC0: out_data_o = SYNC_FIRST;
            ST_SYNC1: out_data_o = SYNC_SECOND;
            ST_LEN:   out_data_o = 8'(q.len) + 8'd1;
            ST_PAY:   out_data_o = pl_data_i;
            ST_CRCH:  out_data_o = q.crc[15:8];
            ST_CRCL:  out_data_o = q.crc[7:0];
            default:  out_data_o = FILL_BYTE;
        endcase
        accept  = out_valid_o && out_ready_i;
        pl_rd_o = (q.st == ST_PAY) && out_ready_i;

        // request arriving while occupied is parked
        if (start_i && !(q.st == ST_IDLE && !q.pend)) begin
            d.pend     = 1'b1;
            d.pend_len = len_i;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (q.pend) begin
                    d.st  = ST_WAIT;
                    d.len = q.pend_len;
                    arm   = 1'b1;
                    if (!start_i) d.pend = 1'b0;
                end else if (start_i) begin
                    d.st  = ST_WAIT;
                    d.len = len_i;
                    arm   = 1'b1;
                end
            end
            ST_WAIT: if (tmr_ready) begin
                d.st   = ST_PRE;
                d.cnt  = '0;
                d.crc  = '0;
                launch = 1'b1;
            end
            ST_PRE: if (accept) begin
                if (q.cnt == CNT_W'(PRE_N - 1)) d.st = ST_SYNC0;
                else d.cnt = q.cnt + 1'b1;
            end
            ST_SYNC0: if (accept) d.st = ST_SYNC1;
            ST_SYNC1: if (accept) d.st = ST_LEN;
            ST_LEN: if (accept) begin
                d.crc = crc_upd;
                d.cnt = '0;
                d.st  = (q.len == '0) ? ST_CRCH : ST_PAY;
            end
            ST_PAY: if (accept) begin
                d.crc = crc_upd;
                if (q.cnt == q.len - 1'b1) d.st = ST_CRCH;
                else d.cnt = q.cnt + 1'b1;
            end
            ST_CRCH: if (accept) d.st = ST_CRCL;
            ST_CRCL: if (accept) begin
                d.st  = ST_TAIL;
                d.cnt = '0;
            end
            ST_TAIL: if (accept) begin
                if (q.cnt == CNT_W'(TAIL_N - 1)) d.st = ST_IDLE;
                else d.cnt = q.cnt + 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign busy_o = (q.st != ST_IDLE) || q.pend;

    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i && q.st != ST_PAY) |=> (out_valid_o && $stable(out_data_o)));
    assert_valid_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> busy_o);
    assert_request_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> busy_o);
    assert_empty_payload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LEN && accept && q.len == '0) |=> (q.st == ST_CRCH && !pl_rd_o));
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (!out_valid_o && !busy_o));
endmodule

// File: tb/nfc_frame_tx_tb.sv
module nfc_frame_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1;
    logic       rx_end_i = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] len_i = '0;
    logic       pl_rd_o;
    logic [7:0] pl_data_i;
    logic       out_valid_o;
    logic [7:0] out_data_o;
    logic       out_ready_i = 1'b1;
    logic       busy_o;

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    int bc;            // model of the tick count
    int earliest_m = 0;
    int pbase = 0, pstep = 0, pidx = 0;

    assign pl_data_i = 8'(pbase + pidx * pstep);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bc <= 0;
        else if (tick_i) bc <= bc + 1;
    end

    nfc_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_end_i(rx_end_i),
        .start_i(start_i), .len_i(len_i), .pl_rd_o(pl_rd_o), .pl_data_i(pl_data_i),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
        .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_add(input logic [15:0] c, input int b);
        logic [15:0] r;
        r = c ^ {8'(b), 8'h00};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    function automatic int slot(input int e, input int n);
        int m;
        m = (e > n) ? e : n;
        return ((m / 8) * 8) + 8;
    endfunction

    int exp_t;

    task automatic issue(input int len);
        @(negedge clk);
        start_i = 1'b1;
        len_i   = 8'(len);
        exp_t   = slot(earliest_m, bc);
    endtask

    task automatic collect(input int len, input int base, input int step, input int slow,
                           input int hold, input int expt, input string rq);
        int e[$];
        logic [15:0] c;
        int k = 0, first = -1, gaps = 0, rds = 0, bad = 0, bad_at = -1, bad_act = 0, it = 0;
        bit prev_rd = 0, held = 0;
        c = 16'h0000;
        for (int i = 0; i < 6; i++) e.push_back(0);
        e.push_back(8'hB2); e.push_back(8'h4D); e.push_back(len + 1);
        c = crc_add(c, len + 1);
        for (int i = 0; i < len; i++) begin
            e.push_back((base + i * step) & 255);
            c = crc_add(c, (base + i * step) & 255);
        end
        e.push_back(int'(c[15:8])); e.push_back(int'(c[7:0]));
        e.push_back(0); e.push_back(0);
        pbase = base; pstep = step; pidx = 0;
        out_ready_i = 1'b1;
        while (k < e.size() && it < 5000) begin
            @(negedge clk);
            it++;
            if (prev_rd) pidx++;
            start_i = 1'b0;
            if (hold >= 0 && !held && k >= 3) begin
                start_i = 1'b1; len_i = 8'(hold); held = 1;
            end
            out_ready_i = slow != 0 ? ~out_ready_i : 1'b1;
            #1;
            if (it == 1) check(busy_o == 1'b1, "R11", "busy after request", int'(busy_o), 1);
            prev_rd = pl_rd_o;
            if (pl_rd_o) rds++;
            if (out_valid_o) begin
                if (first < 0) first = bc;
                if (out_ready_i) begin
                    if (int'(out_data_o) != e[k]) begin
                        bad++;
                        if (bad_at < 0) begin bad_at = k; bad_act = int'(out_data_o); end
                    end
                    k++;
                end
            end else if (first >= 0) gaps++;
        end
        out_ready_i = 1'b1;
        start_i = 1'b0;
        check(it < 5000, rq, "frame completed", it, 5000);
        check(first == expt + 1, rq, "first preamble tick", first, expt + 1);
        check(bad == 0, "R2 R3", "byte stream", bad_act, (bad_at < 0) ? 0 : e[bad_at]);
        check(gaps == 0, "R9", "valid gaps inside frame", gaps, 0);
        check(rds == len, "R10", "payload pops", rds, len);
        earliest_m = (earliest_m > expt + 426) ? earliest_m : expt + 426;
        if (hold < 0) begin
            @(negedge clk); #1;
            check(busy_o == 1'b0, "R11", "busy after frame", int'(busy_o), 0);
        end
    endtask

    // len, base, step, slow ready, idle gap in cycles
    localparam int VEC [0:4][0:4] = '{
        '{4,  16,  1,   0, 0},
        '{1,  165, 0,   1, 500},
        '{8,  240, 17,  0, 37},
        '{3,  0,   128, 1, 700},
        '{16, 90,  3,   0, 3}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        #1;
        check(out_valid_o == 0 && busy_o == 0 && pl_rd_o == 0, "R1", "outputs in reset",
              int'({out_valid_o, busy_o, pl_rd_o}), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(out_valid_o == 0 && busy_o == 0, "R1", "idle after reset",
              int'({out_valid_o, busy_o}), 0);

        // R2 R3 R5 R6 R9 R10: table walk, mixing time-bound and guard-bound launches
        for (int v = 0; v < 5; v++) begin
            repeat (VEC[v][4]) @(negedge clk);
            issue(VEC[v][0]);
            collect(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], -1, exp_t, "R5 R6");
        end

        // R4: empty payload
        repeat (600) @(negedge clk);
        issue(0);
        collect(0, 0, 0, 0, -1, exp_t, "R4");

        // R8: request while busy is held and served after the guard
        repeat (600) @(negedge clk);
        issue(5);
        collect(5, 7, 9, 1, 2, exp_t, "R8");
        collect(2, 200, 5, 0, -1, slot(earliest_m, 0), "R8");

        // R7: turnaround after a received frame end
        repeat (600) @(negedge clk);
        rx_end_i = 1'b1;
        earliest_m = (earliest_m > bc + 168) ? earliest_m : bc + 168;
        @(negedge clk);
        rx_end_i = 1'b0;
        start_i  = 1'b1;
        len_i    = 8'd3;
        exp_t    = slot(earliest_m, bc);
        collect(3, 33, 1, 0, -1, exp_t, "R7");

        // R1: reset in mid-frame
        repeat (600) @(negedge clk);
        issue(6);
        @(negedge clk); start_i = 1'b0;
        while (!out_valid_o) @(negedge clk);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(out_valid_o == 0 && busy_o == 0, "R1", "mid-frame reset",
              int'({out_valid_o, busy_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        earliest_m = 0;
        issue(2);
        collect(2, 1, 1, 0, -1, exp_t, "R1 R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule